// File: doc/BRIEF.md
# In-Order Read Return Reorder Buffer

This block sits between a network-side receive engine and a user that issues fixed-size block reads. Each accepted read command is bound to one 8 KB slot of a local store. The slot number is visible on `cmdSlot` before acceptance. The network side tags every returned 128-bit beat with that slot number and with the beat's offset inside the block. Blocks may finish in any order. The user always receives whole blocks in the order the commands were accepted.

The store holds 2**DEPTH_SEL blocks of 512 beats. DEPTH_SEL ranges from 3 to 7, which gives 64 KB with 8 outstanding reads up to 1 MB with 128. Slots are handed out from a circular pointer, so slot order equals command order. A per-slot completion flag lets the read-out pointer stream the oldest block once all of its beats are present. The slot is released as its final beat is read out.

The user side has a fixed two-cycle response to `outPause`. It also inserts a mandatory idle gap between consecutive blocks.

Top module: `rd_reorder_buf`

## Requirements
- R1: After reset, `cmdReady` is 1, `outValid` is 0 and `cmdSlot` is 0.
- R2: `cmdSlot` shows the slot that the next accepted command receives. Successive accepted commands receive consecutive slot numbers, wrapping modulo 2**DEPTH_SEL (8 slots for the default DEPTH_SEL of 3).
- R3: When every slot holds an outstanding command, `cmdReady` is 0. A request made while it is 0 is not taken, so `cmdSlot` does not move.
- R4: A fill beat is stored at offset `fillBeat` of slot `fillSlot`. A block is output only after all 512 of its beats have been stored. Its beats appear in offset order 0 to 511 with the stored data. When the block is oldest, unpaused and outside a gap, its first beat is valid two cycles after the cycle that carried its final fill beat.
- R5: Blocks are output strictly in command order, whatever order their data arrived in.
- R6: If `outPause` is 1 in cycle c, `outValid` is 0 in cycle c+2. Once pause is low in cycle c, a block in progress resumes with `outValid` 1 in cycle c+2.
- R7: At least two cycles with `outValid` 0 separate the last beat of one block from the first beat of the next.
- R8: With all slots outstanding, `cmdReady` returns to 1 in the same cycle in which `outValid` carries the last beat of the oldest block.
- R9: Fill beats addressed to a slot with no outstanding command, or to a slot whose 512 beats are already complete, are discarded. They neither count toward completion nor alter data.
- R10: A command accepted in the same cycle in which the oldest block's final beat is read out leaves the number of free slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | Read command request |
| cmdReady | output | 1 | A free slot exists; request taken when both are 1 |
| cmdSlot | output | DEPTH_SEL | Slot bound to the next accepted command |
| fillValid | input | 1 | Returned data beat present |
| fillSlot | input | DEPTH_SEL | Slot the returned beat belongs to |
| fillBeat | input | 9 | Beat offset inside the block |
| fillData | input | DATA_W | Returned beat data |
| outValid | output | 1 | User data beat valid |
| outData | output | DATA_W | User data beat |
| outPause | input | 1 | User not ready; stops output two cycles later |

## Verification
The two functions that can meet in one cycle are command admission and slot release. This happens when a new read arrives in the very cycle the oldest block's final beat leaves the store. The bench fills the head block with one slot free, then computes the read-out cycle of its last beat and raises a single request exactly there. The outcome is judged from `cmdReady`. It must still be 1 in the following cycle, so one more command is taken, and it must fall to 0 only after that second acceptance.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  // fixed block geometry: 8 KB as 128-bit beats
  localparam int BLK_BEATS = 512;
  localparam int BEAT_W    = $clog2(BLK_BEATS);

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // store a returned beat
    logic rdEn;   // read one beat toward the user port
  } strobe_t;
endpackage

// File: rtl/rrb_ctrl.sv
module rrb_ctrl import rrb_pkg::*; #(
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  output logic [SLOT_W-1:0] cmdSlot,
  input  logic              fillValid,
  input  logic [SLOT_W-1:0] fillSlot,
  input  logic              outPause,
  output strobe_t           stb,
  output logic [SLOT_W-1:0] rdSlot,
  output logic [BEAT_W-1:0] rdBeat
);
  localparam int SLOTS = 1 << SLOT_W;
  localparam logic [SLOT_W:0] FULL = {1'b1, {SLOT_W{1'b0}}};

  logic [SLOT_W-1:0] allocPtr, rdPtr;
  logic [SLOT_W:0]   used;
  logic [SLOTS-1:0]  busy, done;
  logic [BEAT_W-1:0] beatPtr;
  logic [1:0]        gapCnt;
  logic              pauseQ;
  logic              accept, fillOk, issue, lastIssue;

  assign cmdReady  = (used != FULL);
  assign cmdSlot   = allocPtr;
  assign accept    = cmdValid && cmdReady;
  assign fillOk    = fillValid && busy[fillSlot] && !done[fillSlot];
  assign issue     = busy[rdPtr] && done[rdPtr] && !pauseQ && (gapCnt == 2'd0);
  assign lastIssue = issue && (beatPtr == '1);

  // per-slot occupancy, beat count and completion flag
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              busyR, doneR;
    logic [BEAT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyR <= 1'b0;
        doneR <= 1'b0;
        cnt   <= '0;
      end else if (accept && allocPtr == SLOT_W'(s)) begin
        busyR <= 1'b1;
        doneR <= 1'b0;
        cnt   <= '0;
      end else if (lastIssue && rdPtr == SLOT_W'(s)) begin
        busyR <= 1'b0;
        doneR <= 1'b0;
      end else if (fillOk && fillSlot == SLOT_W'(s)) begin
        cnt <= cnt + 1'b1;
        if (cnt == '1) doneR <= 1'b1;
      end
    end
    assign busy[s] = busyR;
    assign done[s] = doneR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocPtr <= '0;
      rdPtr    <= '0;
      used     <= '0;
      beatPtr  <= '0;
      gapCnt   <= 2'd0;
      pauseQ   <= 1'b0;
    end else begin
      pauseQ <= outPause;
      if (accept)    allocPtr <= allocPtr + 1'b1;
      if (issue)     beatPtr  <= beatPtr + 1'b1;
      if (lastIssue) rdPtr    <= rdPtr + 1'b1;
      if (lastIssue)           gapCnt <= 2'd2;
      else if (gapCnt != 2'd0) gapCnt <= gapCnt - 2'd1;
      unique case ({accept, lastIssue})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.wrEn = fillOk;
    stb.rdEn = issue;
  end
  assign rdSlot = rdPtr;
  assign rdBeat = beatPtr;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    used <= FULL);
  // R7
  blk_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastIssue |=> !issue ##1 !issue);
  // R5
  head_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastIssue |=> (rdPtr == $past(rdPtr) + 1'b1) && (beatPtr == '0));
  // R10
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && lastIssue) |=> used == $past(used));
endmodule

// File: rtl/rrb_store.sv
module rrb_store import rrb_pkg::*; #(
  parameter int SLOT_W = 3,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [BEAT_W-1:0] wrBeat,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [BEAT_W-1:0] rdBeat,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  localparam int ENTRIES = (1 << SLOT_W) * BLK_BEATS;
  localparam int ADDR_W  = SLOT_W + BEAT_W;

  logic [DATA_W-1:0] mem [ENTRIES];
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              validQ;

  assign wrAddr = {wrSlot, wrBeat};
  assign rdAddr = {rdSlot, rdBeat};

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrAddr] <= wrData;
    if (stb.rdEn) outData     <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= stb.rdEn;
  end
  assign outValid = validQ;

  // R4
  valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(stb.rdEn));
endmodule

// File: rtl/rd_reorder_buf.sv
module rd_reorder_buf import rrb_pkg::*; #(
  parameter int DEPTH_SEL = 3,
  parameter int DATA_W    = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  output logic [DEPTH_SEL-1:0] cmdSlot,
  input  logic                 fillValid,
  input  logic [DEPTH_SEL-1:0] fillSlot,
  input  logic [BEAT_W-1:0]    fillBeat,
  input  logic [DATA_W-1:0]    fillData,
  output logic                 outValid,
  output logic [DATA_W-1:0]    outData,
  input  logic                 outPause
);
  strobe_t                stb;
  logic [DEPTH_SEL-1:0]   rdSlot;
  logic [BEAT_W-1:0]      rdBeat;

  rrb_ctrl #(.SLOT_W(DEPTH_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdSlot(cmdSlot),
    .fillValid(fillValid), .fillSlot(fillSlot),
    .outPause(outPause),
    .stb(stb), .rdSlot(rdSlot), .rdBeat(rdBeat)
  );

  rrb_store #(.SLOT_W(DEPTH_SEL), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrSlot(fillSlot), .wrBeat(fillBeat), .wrData(fillData),
    .rdSlot(rdSlot), .rdBeat(rdBeat),
    .outValid(outValid), .outData(outData)
  );

  // R6
  pause_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(outPause, 2) |-> !outValid);
endmodule

// File: tb/tb_rd_reorder_buf.sv
module tb_rd_reorder_buf;
  localparam int DSEL  = 3;
  localparam int SLOTS = 1 << DSEL;
  localparam int BEATS = 512;
  localparam int DW    = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic            cmdValid = 1'b0, cmdReady;
  logic [DSEL-1:0] cmdSlot;
  logic            fillValid = 1'b0;
  logic [DSEL-1:0] fillSlot = '0;
  logic [8:0]      fillBeat = '0;
  logic [DW-1:0]   fillData = '0;
  logic            outValid;
  logic [DW-1:0]   outData;
  logic            outPause;
  logic            manPause = 1'b0, rndOn = 1'b0;
  logic [15:0]     lfsr = 16'hACE1;
  assign outPause = rndOn ? (lfsr[0] & lfsr[3]) : manPause;

  rd_reorder_buf #(.DEPTH_SEL(DSEL), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdSlot(cmdSlot), .fillValid(fillValid), .fillSlot(fillSlot),
    .fillBeat(fillBeat), .fillData(fillData), .outValid(outValid),
    .outData(outData), .outPause(outPause)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] patt(int tag, int beat);
    return {32'(tag), 32'(beat), 32'(tag ^ 32'h5a5a), 32'(beat * 7 + tag)};
  endfunction

  // expected command order and output monitor
  int expQ [0:1023];
  int qWr = 0, qRd = 0, beatIdx = 0, blocksOut = 0, idleCnt = 100, lastBeatCyc = -1;
  logic ph1 = 1'b0, ph2 = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        chk(!ph2, "R6 valid two cycles after pause", 1, 0);
        chk(qRd < qWr, "R4 beat with no block pending", 128'(qRd), 128'(qWr));
        if (beatIdx == 0 && blocksOut > 0)
          chk(idleCnt >= 2, "R7 gap between blocks", 128'(idleCnt), 2);
        chk(outData == patt(expQ[qRd], beatIdx), "R5 block order/data", outData,
            patt(expQ[qRd], beatIdx));
        beatIdx++;
        idleCnt = 0;
        if (beatIdx == BEATS) begin
          beatIdx = 0; qRd++; blocksOut++; lastBeatCyc = cyc;
        end
      end else idleCnt++;
    end
    ph2 = ph1;
    ph1 = outPause;
  end

  task automatic step(); @(posedge clk); #2; endtask
  task automatic samp(); @(negedge clk); #1; endtask

  int issued = 0;
  task automatic push_cmd();
    expQ[qWr] = issued; qWr++; issued++;
  endtask

  // R2 slot numbering checked on every request
  task automatic issue_cmd();
    step(); cmdValid = 1'b1; samp();
    chk(cmdReady == 1'b1, "R3 ready with free slot", 128'(cmdReady), 1);
    chk(cmdSlot == DSEL'(issued % SLOTS), "R2 slot number", 128'(cmdSlot),
        128'(issued % SLOTS));
    push_cmd();
  endtask

  task automatic fill_beats(int tag, int slot, int first, int last);
    for (int b = first; b <= last; b++) begin
      step();
      fillValid = 1'b1; fillSlot = DSEL'(slot); fillBeat = 9'(b);
      fillData = patt(tag, b);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin step(); fillValid = 1'b0; cmdValid = 1'b0; end
  endtask

  task automatic drain();
    while (blocksOut < qWr) begin step(); fillValid = 1'b0; cmdValid = 1'b0; end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // vector table: {commands, fill order (0 fwd, 1 reverse, 2 interleaved reverse), random pause}
  localparam int VEC [4][3] = '{'{3, 0, 0}, '{4, 1, 0}, '{SLOTS, 2, 0}, '{5, 1, 1}};

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 128'(cyc), 0);
    summary();
  end

  initial begin
    int base, n, t, fc, vcount, c0;
    repeat (5) @(posedge clk);
    step(); rstN = 1'b1; samp();
    // R1
    chk(cmdReady == 1'b1, "R1 reset ready", 128'(cmdReady), 1);
    chk(outValid == 1'b0, "R1 reset valid", 128'(outValid), 0);
    chk(cmdSlot == '0, "R1 reset slot", 128'(cmdSlot), 0);

    for (int v = 0; v < 4; v++) begin
      n = VEC[v][0]; base = issued;
      for (int i = 0; i < n; i++) issue_cmd();
      step(); cmdValid = 1'b0;
      rndOn = VEC[v][2][0];
      if (VEC[v][1] == 0)
        for (int i = 0; i < n; i++) fill_beats(base + i, (base + i) % SLOTS, 0, BEATS - 1);
      else if (VEC[v][1] == 1)
        for (int i = n - 1; i >= 0; i--) fill_beats(base + i, (base + i) % SLOTS, 0, BEATS - 1);
      else
        for (int b = 0; b < BEATS; b++)
          for (int i = n - 1; i >= 0; i--) fill_beats(base + i, (base + i) % SLOTS, b, b);
      drain();
      rndOn = 1'b0;
      samp();
      // R5
      chk(blocksOut == qWr, "R5 all blocks returned", 128'(blocksOut), 128'(qWr));
    end

    // R3 / R4 / R8: fill the buffer, refuse extra requests, free on last beat
    base = issued;
    for (int i = 0; i < SLOTS; i++) issue_cmd();
    step(); cmdValid = 1'b0; samp();
    chk(cmdReady == 1'b0, "R3 full", 128'(cmdReady), 0);
    for (int i = 0; i < 3; i++) begin step(); cmdValid = 1'b1; samp(); end
    step(); cmdValid = 1'b0; samp();
    chk(cmdSlot == DSEL'(issued % SLOTS), "R3 refused request not taken", 128'(cmdSlot),
        128'(issued % SLOTS));
    fill_beats(base, base % SLOTS, 0, BEATS - 1);
    fc = cyc;
    while (cyc < fc + BEATS + 1) begin
      step(); fillValid = 1'b0; samp();
      if (cyc == fc + 1) chk(!outValid, "R4 no beat one cycle after fill", 128'(outValid), 0);
      if (cyc == fc + 2) chk(outValid, "R4 first beat two cycles after fill", 128'(outValid), 1);
      if (cyc == fc + BEATS) chk(!cmdReady, "R8 still full before last beat", 128'(cmdReady), 0);
    end
    chk(cmdReady, "R8 slot free at last beat", 128'(cmdReady), 1);
    chk(lastBeatCyc == fc + BEATS + 1, "R8 last beat cycle", 128'(lastBeatCyc),
        128'(fc + BEATS + 1));

    // R10: admission in the cycle of the head block's final read
    fill_beats(base + 1, (base + 1) % SLOTS, 0, BEATS - 1);
    fc = cyc;
    while (cyc < fc + BEATS - 1) begin step(); fillValid = 1'b0; samp(); end
    step(); cmdValid = 1'b1; samp();
    chk(cmdReady, "R10 ready at release cycle", 128'(cmdReady), 1);
    push_cmd();
    step(); cmdValid = 1'b1; samp();
    chk(cmdReady, "R10 one slot still free", 128'(cmdReady), 1);
    push_cmd();
    step(); cmdValid = 1'b0; samp();
    chk(!cmdReady, "R10 full after second accept", 128'(cmdReady), 0);
    for (int tg = base + 2; tg < issued; tg++) fill_beats(tg, tg % SLOTS, 0, BEATS - 1);
    drain();

    // R9: stray beats to free slots are discarded
    t = issued;
    fill_beats(9999, t % SLOTS, 0, BEATS - 1);
    fill_beats(9999, (t + 1) % SLOTS, 0, BEATS - 1);
    issue_cmd();
    step(); cmdValid = 1'b0;
    fill_beats(t, t % SLOTS, 0, BEATS - 2);
    vcount = 0;
    for (int i = 0; i < 12; i++) begin step(); fillValid = 1'b0; samp(); vcount += int'(outValid); end
    chk(vcount == 0, "R9 stray beats not counted", 128'(vcount), 0);
    step(); manPause = 1'b1;
    fill_beats(t, t % SLOTS, BEATS - 1, BEATS - 1);
    fill_beats(8888, t % SLOTS, 0, 3);   // R9 beats to a completed slot
    vcount = 0;
    for (int i = 0; i < 10; i++) begin step(); fillValid = 1'b0; samp(); vcount += int'(outValid); end
    chk(vcount == 0, "R6 held while paused", 128'(vcount), 0);

    // R6 exact latency on release and on raise
    step(); manPause = 1'b0; c0 = cyc; samp();
    step(); samp(); chk(!outValid, "R6 still idle one cycle after release", 128'(outValid), 0);
    step(); samp(); chk(outValid, "R6 resume two cycles after release", 128'(outValid), 1);
    step(); samp();
    step(); manPause = 1'b1; samp();
    step(); samp(); chk(outValid, "R6 still valid one cycle after pause", 128'(outValid), 1);
    step(); samp(); chk(!outValid, "R6 stop two cycles after pause", 128'(outValid), 0);
    step(); samp();
    step(); manPause = 1'b0; samp();
    chk(cyc == c0 + 8, "R6 sequence timing", 128'(cyc), 128'(c0 + 8));
    drain();
    samp();
    chk(blocksOut == qWr, "R9 block delivered with its own data", 128'(blocksOut), 128'(qWr));
    summary();
  end
endmodule